// File: doc/BRIEF.md
# SIMD Lane Utilization Counter

This block sits beside the issue stage of a SIMD engine with a configurable number of lanes, where the warp width equals the lane count. Each time a warp instruction issues, the block receives that instruction's active-thread mask. It keeps two running totals. The first is the number of lanes that held an active thread. The second is the number of lane slots the machine offered. Software divides the first total by the second to obtain the program's SIMD utilization over the whole run.

An instruction whose mask has no bits set is treated as never issued, so it adds nothing to either total. A partially filled final warp still offers the full lane width for each instruction it issues. Only its active threads count as busy. Both totals can be cleared and frozen. They saturate at their maximum value instead of wrapping.

Top module: `simd_util_counter`

## Requirements
- R1: While reset is asserted, and after it is released until the first qualifying issue, both `busy_cnt` and `slot_cnt` read zero.
- R2: A qualifying issue adds the number of ones in `act_mask` to `busy_cnt`. A qualifying issue is one where `issue_vld`=1, `cnt_en`=1, `cnt_clr`=0 and `act_mask` is non-zero. The new value is visible on the clock edge that samples the issue.
- R3: A qualifying issue adds exactly LANES to `slot_cnt`, however many mask bits are set. A partial warp therefore costs the full width.
- R4: An issue strobe with an all-zero `act_mask` leaves both counters unchanged.
- R5: When `issue_vld`=0, both counters are unchanged, whatever `act_mask` holds.
- R6: When `cnt_en`=0, both counters hold their value even on a valid non-empty issue.
- R7: `cnt_clr`=1 sets both counters to zero on the next edge. It takes priority over a coincident issue, and it acts even while `cnt_en`=0.
- R8: Each counter stops at 2^CNT_W-1 when an addition would exceed that value, and it never wraps to a smaller value.
- R9: `busy_cnt` never exceeds `slot_cnt`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue_vld | input | 1 | A warp instruction is presented this cycle |
| act_mask | input | LANES | Active-thread mask of the presented instruction, bit i = lane i |
| cnt_en | input | 1 | Accumulation enable; low freezes both counters |
| cnt_clr | input | 1 | Synchronous clear of both counters |
| busy_cnt | output | CNT_W | Accumulated active lanes |
| slot_cnt | output | CNT_W | Accumulated lane slots offered |

## Verification
The bench builds two instances side by side. The first has 64 lanes and a 14-bit counter width, so saturation is reached after 256 full-width issues and the clamp can be checked within a short run. The second uses the default 32 lanes and 32-bit counters. It sees only the low half of the same mask, so a mask whose set bits all lie in the upper half is empty for this instance and non-empty for the other.

// File: rtl/simd_util_pkg.sv
package simd_util_pkg;

  // Width needed to hold a count from 0 to n inclusive.
  function automatic int unsigned count_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/simd_rst_sync.sv
module simd_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign srst_n = stage_q[1];

endmodule

// File: rtl/simd_popcount.sv
module simd_popcount
  import simd_util_pkg::*;
#(
  parameter int unsigned LANES = 32,
  parameter int unsigned GROUP = 8,
  localparam int unsigned OUT_W = count_width(LANES)
) (
  input  logic [LANES-1:0] mask,
  output logic [OUT_W-1:0] count
);

  localparam int unsigned NGRP = (LANES + GROUP - 1) / GROUP;
  localparam int unsigned PAD  = NGRP * GROUP;
  localparam int unsigned GW   = count_width(GROUP);

  logic [PAD-1:0] padded;
  logic [GW-1:0]  grp_cnt [NGRP];

  always_comb begin
    padded              = '0;
    padded[LANES-1:0]   = mask;
  end

  // One small counter per group of lanes.
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GW-1:0] part;
    always_comb begin
      part = '0;
      for (int b = 0; b < GROUP; b++) begin
        part = part + GW'(padded[g*GROUP + b]);
      end
    end
    assign grp_cnt[g] = part;
  end

  // Sum the group counts.
  always_comb begin
    count = '0;
    for (int g = 0; g < NGRP; g++) begin
      count = count + OUT_W'(grp_cnt[g]);
    end
  end

endmodule

// File: rtl/simd_sat_accum.sv
module simd_sat_accum #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned INC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add_en,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] acc
);

  localparam logic [CNT_W-1:0] ACC_MAX = '1;

  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] acc_q;
  logic [CNT_W-1:0] acc_d;
  logic             acc_ld;

  // Next-state logic
  always_comb begin
    sum    = {1'b0, acc_q} + (CNT_W+1)'(inc);
    acc_ld = clr | add_en;
    if (clr) begin
      acc_d = '0;
    end else if (sum[CNT_W]) begin
      acc_d = ACC_MAX;
    end else begin
      acc_d = sum[CNT_W-1:0];
    end
  end

  // State register with explicit load enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_ld) begin
      acc_q <= acc_d;
    end
  end

  assign acc = acc_q;

endmodule

// File: rtl/simd_util_counter.sv
module simd_util_counter
  import simd_util_pkg::*;
#(
  parameter int unsigned LANES = 32,
  parameter int unsigned CNT_W = 32,
  parameter int unsigned GROUP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_vld,
  input  logic [LANES-1:0] act_mask,
  input  logic             cnt_en,
  input  logic             cnt_clr,
  output logic [CNT_W-1:0] busy_cnt,
  output logic [CNT_W-1:0] slot_cnt
);

  localparam int unsigned PC_W = count_width(LANES);
  localparam logic [PC_W-1:0] SLOT_STEP = PC_W'(LANES);

  logic            rst_int_n;
  logic [PC_W-1:0] pop;
  logic            mask_any;
  logic            qualify;

  simd_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_int_n)
  );

  simd_popcount #(
    .LANES (LANES),
    .GROUP (GROUP)
  ) u_popcount (
    .mask  (act_mask),
    .count (pop)
  );

  // An empty mask means nothing was issued.
  always_comb begin
    mask_any = |act_mask;
    qualify  = issue_vld & cnt_en & mask_any & ~cnt_clr;
  end

  simd_sat_accum #(
    .CNT_W (CNT_W),
    .INC_W (PC_W)
  ) u_busy_acc (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr    (cnt_clr),
    .add_en (qualify),
    .inc    (pop),
    .acc    (busy_cnt)
  );

  simd_sat_accum #(
    .CNT_W (CNT_W),
    .INC_W (PC_W)
  ) u_slot_acc (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr    (cnt_clr),
    .add_en (qualify),
    .inc    (SLOT_STEP),
    .acc    (slot_cnt)
  );

endmodule

// File: rtl/simd_util_chk.sv
module simd_util_chk #(
  parameter int unsigned LANES = 32,
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue_vld,
  input logic [LANES-1:0] act_mask,
  input logic             cnt_en,
  input logic             cnt_clr,
  input logic [CNT_W-1:0] busy_cnt,
  input logic [CNT_W-1:0] slot_cnt
);

  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] STEP = CNT_W'(LANES);
  localparam logic [CNT_W-1:0] HEAD = CMAX - STEP;

  logic qual;
  assign qual = issue_vld && cnt_en && !cnt_clr && (act_mask != '0);

  // R1
  always_comb begin
    if (!rst_n) begin
      a_r1_reset_zero: assert (busy_cnt == '0 && slot_cnt == '0);
    end
  end

  a_r2_busy_step: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && busy_cnt <= HEAD) |=>
      busy_cnt == $past(busy_cnt) + CNT_W'($countones($past(act_mask))));

  a_r3_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && slot_cnt <= HEAD) |=> slot_cnt == $past(slot_cnt) + STEP);

  a_r4_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && act_mask == '0 && !cnt_clr) |=>
      ($stable(busy_cnt) && $stable(slot_cnt)));

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue_vld && !cnt_clr) |=> ($stable(busy_cnt) && $stable(slot_cnt)));

  a_r6_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !cnt_clr) |=> ($stable(busy_cnt) && $stable(slot_cnt)));

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (busy_cnt == '0 && slot_cnt == '0));

  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> (slot_cnt >= $past(slot_cnt) && busy_cnt >= $past(busy_cnt)));

  a_r9_busy_le_slot: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= slot_cnt);

endmodule

bind simd_util_counter simd_util_chk #(
  .LANES (LANES),
  .CNT_W (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .issue_vld (issue_vld),
  .act_mask  (act_mask),
  .cnt_en    (cnt_en),
  .cnt_clr   (cnt_clr),
  .busy_cnt  (busy_cnt),
  .slot_cnt  (slot_cnt)
);

// File: tb/simd_util_counter_tb.sv
module simd_util_counter_tb;

  localparam int L0 = 64;
  localparam int W0 = 14;
  localparam int L1 = 32;
  localparam int W1 = 32;
  localparam longint MAX0 = (longint'(1) << W0) - 1;
  localparam longint MAX1 = (longint'(1) << W1) - 1;

  logic          clk;
  logic          rst_n;
  logic          vld;
  logic [63:0]   mask;
  logic          en;
  logic          clr;
  logic [W0-1:0] busy0, slot0;
  logic [W1-1:0] busy1, slot1;

  int n_chk;
  int n_err;
  bit done;

  longint mb0, ms0, mb1, ms1;

  simd_util_counter #(.LANES(L0), .CNT_W(W0)) u_dut (
    .clk(clk), .rst_n(rst_n), .issue_vld(vld), .act_mask(mask),
    .cnt_en(en), .cnt_clr(clr), .busy_cnt(busy0), .slot_cnt(slot0)
  );

  simd_util_counter #(.LANES(L1), .CNT_W(W1)) u_dut_w32 (
    .clk(clk), .rst_n(rst_n), .issue_vld(vld), .act_mask(mask[31:0]),
    .cnt_en(en), .cnt_clr(clr), .busy_cnt(busy1), .slot_cnt(slot1)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic longint sat(input longint v, input longint m);
    return (v > m) ? m : v;
  endfunction

  // Behavioural reference model of both instances.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mb0 <= 0; ms0 <= 0; mb1 <= 0; ms1 <= 0;
    end else if (clr) begin
      mb0 <= 0; ms0 <= 0; mb1 <= 0; ms1 <= 0;
    end else if (vld && en) begin
      if (mask != 64'd0) begin
        mb0 <= sat(mb0 + $countones(mask), MAX0);
        ms0 <= sat(ms0 + L0, MAX0);
      end
      if (mask[31:0] != 32'd0) begin
        mb1 <= sat(mb1 + $countones(mask[31:0]), MAX1);
        ms1 <= sat(ms1 + L1, MAX1);
      end
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  // Compare against the model every cycle (R2 busy, R3 slot, R9 order).
  task automatic compare_all();
    chk("R2 busy 64-lane", longint'(busy0), mb0);
    chk("R3 slot 64-lane", longint'(slot0), ms0);
    chk("R2 busy 32-lane", longint'(busy1), mb1);
    chk("R3 slot 32-lane", longint'(slot1), ms1);
    chk("R9 busy<=slot", longint'(busy0 <= slot0 && busy1 <= slot1), 1);
  endtask

  // Apply inputs at a falling edge, advance one cycle, compare.
  task automatic cyc(input logic v, input logic [63:0] m, input logic e, input logic c);
    vld = v; mask = m; en = e; clr = c;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    longint b0, s0, b1, s1;
    n_chk = 0; n_err = 0; done = 1'b0;
    rst_n = 1'b0; vld = 1'b0; mask = '0; en = 1'b1; clr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset busy", longint'(busy0) + longint'(busy1), 0);
    chk("R1 reset slot", longint'(slot0) + longint'(slot1), 0);
    rst_n = 1'b1;
    repeat (3) cyc(1'b0, 64'd0, 1'b1, 1'b0);
    chk("R1 after release", longint'(busy0 | slot0), 0);

    // R2 / R3: full warp, partial warp, upper-half-only mask
    cyc(1'b1, '1, 1'b1, 1'b0);
    chk("R2 full 64", longint'(busy0), 64);
    chk("R3 full 32", longint'(slot1), 32);
    b0 = busy0; s0 = slot0;
    cyc(1'b1, 64'h1F, 1'b1, 1'b0);
    chk("R2 partial busy", longint'(busy0), b0 + 5);
    chk("R3 partial slot", longint'(slot0), s0 + 64);
    b1 = busy1; s1 = slot1; s0 = slot0;
    cyc(1'b1, 64'hF000_0000_0000_0000, 1'b1, 1'b0);
    chk("R4 upper-only empty for 32-lane busy", longint'(busy1), b1);
    chk("R4 upper-only empty for 32-lane slot", longint'(slot1), s1);
    chk("R3 upper-only 64-lane slot", longint'(slot0), s0 + 64);

    // R4: empty mask
    b0 = busy0; s0 = slot0;
    cyc(1'b1, 64'd0, 1'b1, 1'b0);
    chk("R4 empty busy", longint'(busy0), b0);
    chk("R4 empty slot", longint'(slot0), s0);

    // R5: no strobe
    cyc(1'b0, '1, 1'b1, 1'b0);
    chk("R5 idle busy", longint'(busy0), b0);
    chk("R5 idle slot", longint'(slot0), s0);

    // R6: frozen
    cyc(1'b1, '1, 1'b0, 1'b0);
    chk("R6 frozen busy", longint'(busy0), b0);
    chk("R6 frozen slot", longint'(slot0), s0);

    // R7: clear beats issue, and acts while frozen
    cyc(1'b1, '1, 1'b1, 1'b1);
    chk("R7 clear priority", longint'(busy0 | slot0 | busy1 | slot1), 0);
    cyc(1'b1, '1, 1'b1, 1'b0);
    cyc(1'b0, 64'd0, 1'b0, 1'b1);
    chk("R7 clear while frozen", longint'(busy0 | slot0 | busy1 | slot1), 0);

    // Mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      logic [63:0] m;
      int sel;
      sel = $urandom_range(0, 7);
      m = {$urandom, $urandom};
      if (sel == 0) m = 64'd0;
      else if (sel == 1) m = m & {$urandom, $urandom} & {$urandom, $urandom};
      else if (sel == 2) m = {m[63:32], 32'd0};
      cyc(($urandom_range(0, 3) != 0), m, ($urandom_range(0, 5) != 0),
          ($urandom_range(0, 60) == 0));
    end

    // R8: saturation of the 14-bit instance
    cyc(1'b0, 64'd0, 1'b1, 1'b1);
    for (int i = 0; i < 255; i++) cyc(1'b1, '1, 1'b1, 1'b0);
    chk("R8 below limit", longint'(slot0), 255 * 64);
    cyc(1'b1, '1, 1'b1, 1'b0);
    chk("R8 clamp slot", longint'(slot0), MAX0);
    chk("R8 clamp busy", longint'(busy0), MAX0);
    for (int i = 0; i < 4; i++) cyc(1'b1, '1, 1'b1, 1'b0);
    chk("R8 held slot", longint'(slot0), MAX0);
    chk("R8 wide instance", longint'(slot1), 260 * 32);
    cyc(1'b1, 64'h1, 1'b1, 1'b0);
    chk("R8 held busy", longint'(busy0), MAX0);
    chk("R9 at limit", longint'(busy0 <= slot0), 1);

    cyc(1'b0, 64'd0, 1'b1, 1'b0);
    finish_run();
  end

endmodule